// File: doc/BRIEF.md
# I2C Serial EEPROM Write Controller

This block is the target side of a byte-wide serial EEPROM on a two-wire I2C bus, limited to the write path. It oversamples the bus clock and data lines with the system clock and recognises Start and Stop conditions. It accepts a device select byte, a high and a low address byte, and then a burst of data bytes. It acknowledges each byte by pulling SDA low through an open-drain enable. The data bytes collect in a page buffer. They reach the 4096 x 8 storage array only during a timed internal write cycle, and that cycle begins only when a Stop arrives in the correct bit slot.

A write-control input lets the board forbid writes. While the internal write cycle runs, the block stays off the bus completely and raises a busy flag. A side read port shows the array contents, and a pointer output shows the internal address counter, so that the surrounding logic can observe both.

Top module: `eewr_ctl`

## Requirements
- R1: Both lines pass through a two-flop synchronizer. A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. A Start in the middle of a transaction begins a new one.
- R2: After a Start, a select byte equal to {DEV_CODE, 0} is acknowledged. Acknowledging means `sda_oe_o`=1 (SDA pulled low) during the ninth SCL clock. Any other value, including R/W=1, gets no acknowledge, and the block ignores the bus until the next Start.
- R3: The next two bytes are the high and then the low address byte, and each is acknowledged. Only A11..A0 choose the location. A15..A12 have no effect.
- R4: With `wc_i` low, every data byte is acknowledged and placed in page A11..A5 at offset (A4..A0 + n) mod 32, where n counts the data bytes sent before it. A burst longer than 32 bytes overwrites earlier bytes of the same page.
- R5: The internal write starts only for a Stop that arrives before the second SCL rise after a data byte's acknowledge clock. A Stop at any other point drops the transaction: the array is unchanged and busy stays low.
- R6: Once a write starts, `busy_o` is high for exactly WR_CYCLES clock cycles. All buffered bytes are in the array when busy falls.
- R7: While `busy_o` is high, `sda_oe_o` stays 0. Start conditions and the block's own select code get no response.
- R8: With `wc_i` high, data bytes are not acknowledged and nothing is written. The select byte and both address bytes are still acknowledged.
- R9: When a write cycle ends, `ptr_o` holds {A11..A5, (A4..A0 + count) mod 32}, which is the byte after the last one written within the page. A dropped or inhibited transaction leaves `ptr_o` unchanged.
- R10: After reset, `busy_o`=0, `sda_oe_o`=0 and `ptr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired value) |
| wc_i | input | 1 | Write control; high forbids writes |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | ADDR_W | Internal address counter |
| rd_addr_i | input | ADDR_W | Array side-read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |

## Verification
The bench runs bursts with random page, offset, upper address bits and length, up to 40 bytes. This separates correct in-page wraparound from linear addressing and shows whether A15..A12 leak into the location. Directed cases cover a wrong select code, a read request, a Stop straight after the address and a Stop partway through a data byte, which together separate a Stop in the commit slot from a Stop anywhere else. Held write-control transactions separate inhibited data acknowledges from the still-acknowledged select and address bytes. A select sent during the write cycle and a repeated Start in mid-transaction check that the block stays silent and restarts cleanly.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } eewr_state_e;

  // bit-slot counter values around the acknowledge clock
  localparam logic [3:0] SLOT_LAST_BIT = 4'd7;
  localparam logic [3:0] SLOT_ACK_WAIT = 4'd8;
  localparam logic [3:0] SLOT_ACK_CLK  = 4'd9;

endpackage

// File: rtl/eewr_bus_cond.sv
module eewr_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eewr_proto.sv
module eewr_proto
  import eewr_pkg::*;
#(
  parameter logic [6:0] DEV_CODE = 7'h50,
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              wc_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              buf_clr_o,
  output logic              buf_we_o,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic [7:0]        buf_data_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_base_o,
  output logic [PAGE_W-1:0] commit_cnt_o
);

  localparam int HI_W = ADDR_W - 8;

  eewr_state_e       state_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic [HI_W-1:0]   addr_hi_q;
  logic [ADDR_W-1:0] base_q;
  logic [PAGE_W-1:0] cnt_q;
  logic              ack_pend_q, oe_q, stop_ok_q, inhibit_q, any_q;

  // named internal events
  logic       live, byte_done, sel_match;
  logic [7:0] full_byte;

  function automatic logic [PAGE_W-1:0] slot_of(input logic [PAGE_W-1:0] off,
                                                input logic [PAGE_W-1:0] n);
    return off + n;
  endfunction

  assign live      = !busy_i && !start_det && !stop_det;
  assign full_byte = {shreg_q[6:0], sda_s};
  assign byte_done = live && scl_rise && (state_q != ST_IDLE) && (bitcnt_q == SLOT_LAST_BIT);
  assign sel_match = (full_byte == {DEV_CODE, 1'b0});

  assign buf_we_o      = byte_done && (state_q == ST_DATA) && !wc_i;
  assign buf_idx_o     = slot_of(base_q[PAGE_W-1:0], cnt_q);
  assign buf_data_o    = full_byte;
  assign buf_clr_o     = byte_done && (state_q == ST_ALO);
  assign commit_o      = !busy_i && stop_det && (state_q == ST_DATA) &&
                         stop_ok_q && any_q && !inhibit_q;
  assign commit_base_o = base_q;
  assign commit_cnt_o  = cnt_q;
  assign sda_oe_o      = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      addr_hi_q  <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      ack_pend_q <= 1'b0;
      oe_q       <= 1'b0;
      stop_ok_q  <= 1'b0;
      inhibit_q  <= 1'b0;
      any_q      <= 1'b0;
    end else if (busy_i) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      ack_pend_q <= 1'b0;
      oe_q       <= 1'b0;
      stop_ok_q  <= 1'b0;
    end else if (start_det) begin
      state_q    <= ST_SEL;
      bitcnt_q   <= '0;
      ack_pend_q <= 1'b0;
      oe_q       <= 1'b0;
      stop_ok_q  <= 1'b0;
      inhibit_q  <= 1'b0;
      any_q      <= 1'b0;
      cnt_q      <= '0;
    end else if (stop_det) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      ack_pend_q <= 1'b0;
      oe_q       <= 1'b0;
      stop_ok_q  <= 1'b0;
    end else if (scl_rise && state_q != ST_IDLE) begin
      if (bitcnt_q < SLOT_ACK_WAIT) begin
        shreg_q  <= full_byte;
        bitcnt_q <= bitcnt_q + 4'd1;
        if (bitcnt_q == 4'd1) stop_ok_q <= 1'b0;
      end else if (bitcnt_q == SLOT_ACK_WAIT) begin
        bitcnt_q <= SLOT_ACK_CLK;
      end
      if (byte_done) begin
        unique case (state_q)
          ST_SEL: begin
            if (sel_match) begin
              ack_pend_q <= 1'b1;
              state_q    <= ST_AHI;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_AHI: begin
            addr_hi_q  <= full_byte[HI_W-1:0];
            ack_pend_q <= 1'b1;
            state_q    <= ST_ALO;
          end
          ST_ALO: begin
            base_q     <= {addr_hi_q, full_byte};
            ack_pend_q <= 1'b1;
            cnt_q      <= '0;
            any_q      <= 1'b0;
            inhibit_q  <= 1'b0;
            state_q    <= ST_DATA;
          end
          ST_DATA: begin
            if (!wc_i) begin
              ack_pend_q <= 1'b1;
              cnt_q      <= cnt_q + 1'b1;
              any_q      <= 1'b1;
            end else begin
              inhibit_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end else if (scl_fall && state_q != ST_IDLE) begin
      if (bitcnt_q == SLOT_ACK_WAIT && ack_pend_q) oe_q <= 1'b1;
      if (bitcnt_q == SLOT_ACK_CLK) begin
        oe_q       <= 1'b0;
        ack_pend_q <= 1'b0;
        bitcnt_q   <= '0;
        if (state_q == ST_DATA) stop_ok_q <= 1'b1;
      end
    end
  end

  // R2: the acknowledge drive only exists in the ninth-bit window
  p_oe_in_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (bitcnt_q == SLOT_ACK_WAIT || bitcnt_q == SLOT_ACK_CLK));

  // R8: an inhibited data phase never drives a data acknowledge
  p_no_data_ack_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && state_q == ST_DATA && bitcnt_q == SLOT_ACK_CLK) |-> !inhibit_q);

  // R5: a commit is always followed by an idle protocol engine
  p_idle_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (state_q == ST_IDLE && !sda_oe_o));

endmodule

// File: rtl/eewr_store.sv
module eewr_store #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr_i,
  input  logic              buf_we_i,
  input  logic [PAGE_W-1:0] buf_idx_i,
  input  logic [7:0]        buf_data_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] commit_base_i,
  input  logic [PAGE_W-1:0] commit_cnt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o
);

  localparam int PG    = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CYC   = (WR_CYCLES > PG) ? WR_CYCLES : PG;
  localparam int TW    = $clog2(CYC + 1);
  localparam int PN_W  = ADDR_W - PAGE_W;

  logic [7:0]        pbuf_q [PG];
  logic [PG-1:0]     pvld_q;
  logic [7:0]        mem_q  [DEPTH];
  logic [PN_W-1:0]   page_q;
  logic [ADDR_W-1:0] next_q, ptr_q;
  logic [TW-1:0]     tmr_q;
  logic              busy_q;

  logic              copy_on, mem_we, cycle_end;
  logic [PAGE_W-1:0] copy_idx;

  function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] base,
                                                 input logic [PAGE_W-1:0] cnt);
    logic [PAGE_W-1:0] off;
    off = base[PAGE_W-1:0] + cnt;
    return {base[ADDR_W-1:PAGE_W], off};
  endfunction

  assign copy_idx  = tmr_q[PAGE_W-1:0];
  assign copy_on   = busy_q && (tmr_q < TW'(PG));
  assign mem_we    = copy_on && pvld_q[copy_idx];
  assign cycle_end = busy_q && (tmr_q == TW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (buf_we_i) pbuf_q[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[{page_q, copy_idx}] <= pbuf_q[copy_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld_q <= '0;
      page_q <= '0;
      next_q <= '0;
      ptr_q  <= '0;
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      tmr_q <= tmr_q + 1'b1;
      if (cycle_end) begin
        busy_q <= 1'b0;
        ptr_q  <= next_q;
        pvld_q <= '0;
      end
    end else if (commit_i) begin
      busy_q <= 1'b1;
      tmr_q  <= '0;
      page_q <= commit_base_i[ADDR_W-1:PAGE_W];
      next_q <= next_ptr(commit_base_i, commit_cnt_i);
    end else if (buf_clr_i) begin
      pvld_q <= '0;
    end else if (buf_we_i) begin
      pvld_q[buf_idx_i] <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;
  assign ptr_o     = ptr_q;

  // R6: a commit from the protocol side always opens a write cycle
  p_commit_opens_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> busy_q);

  // R7: nothing reaches the page buffer while the write cycle runs
  p_no_buffer_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_i |-> !busy_q);

  // R9: the pointer moves only when a write cycle ends
  p_ptr_stable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> $stable(ptr_q));

endmodule

// File: rtl/eewr_ctl.sv
module eewr_ctl #(
  parameter logic [6:0] DEV_CODE    = 7'h50,
  parameter int         ADDR_W      = 12,
  parameter int         PAGE_W      = 5,
  parameter int         WR_CYCLES   = 400,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wc_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  logic              scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic              buf_clr, buf_we, commit;
  logic [PAGE_W-1:0] buf_idx, commit_cnt;
  logic [7:0]        buf_data;
  logic [ADDR_W-1:0] commit_base;

  eewr_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  eewr_proto #(.DEV_CODE(DEV_CODE), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .wc_i(wc_i), .busy_i(busy_o), .sda_oe_o(sda_oe_o),
    .buf_clr_o(buf_clr), .buf_we_o(buf_we), .buf_idx_o(buf_idx),
    .buf_data_o(buf_data), .commit_o(commit),
    .commit_base_o(commit_base), .commit_cnt_o(commit_cnt)
  );

  eewr_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .buf_clr_i(buf_clr), .buf_we_i(buf_we), .buf_idx_i(buf_idx),
    .buf_data_i(buf_data), .commit_i(commit),
    .commit_base_i(commit_base), .commit_cnt_i(commit_cnt),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .ptr_o(ptr_o)
  );

  // R7: silent on the bus for the whole write cycle
  p_silent_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

endmodule

// File: tb/sim_eewr_ctl.sv
module sim_eewr_ctl;

  localparam int WRC = 400;
  localparam logic [6:0] CODE = 7'h50;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic [11:0] rd_addr = '0;
  logic        sda_oe, busy;
  logic [11:0] ptr;
  logic [7:0]  rd_data;
  wire         sda_bus = sda_m & ~sda_oe;

  eewr_ctl #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .wc_i(wc),
    .sda_oe_o(sda_oe), .busy_o(busy), .ptr_o(ptr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [7:0]  model [4096];
  logic [11:0] exp_ptr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int slot(input int off, input int k);
    return (off + k) % 32;
  endfunction

  task automatic tx_start();
    sda_m = 1'b1; w(4); scl_m = 1'b1; w(8);
    sda_m = 1'b0; w(8); scl_m = 1'b0; w(4);
  endtask

  task automatic tx_bit(input bit b);
    sda_m = b; w(4); scl_m = 1'b1; w(8); scl_m = 1'b0; w(4);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
    sda_m = 1'b1; w(4); scl_m = 1'b1; w(4);
    ack = !sda_bus;
    w(4); scl_m = 1'b0; w(4);
  endtask

  // ends right at the SDA rise; callers wait afterwards
  task automatic tx_stop();
    sda_m = 1'b0; w(4); scl_m = 1'b1; w(8); sda_m = 1'b1;
  endtask

  task automatic check_page(input int page, input string req);
    int bad = 0, a_bad = 0, e_bad = 0;
    for (int k = 0; k < 32; k++) begin
      rd_addr = 12'(page * 32 + k);
      #1;
      if (rd_data !== model[page * 32 + k]) begin
        if (bad == 0) begin a_bad = rd_data; e_bad = model[page * 32 + k]; end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("page %0d content", page), a_bad, e_bad);
  endtask

  // full write transaction; abort_bits>0 stops partway through one more byte
  task automatic write_txn(input logic [15:0] a, input int n, input bit wcv,
                           input int abort_bits, input bit probe);
    bit ack, commit;
    int page, off, t, bc;
    logic [7:0] pg [32];
    logic [7:0] d;
    page = int'(a[11:5]); off = int'(a[4:0]);
    for (int k = 0; k < 32; k++) pg[k] = model[page * 32 + k];
    wc = wcv;
    tx_start();
    tx_byte({CODE, 1'b0}, ack); chk(ack, "R2", "select ack", ack, 1);
    tx_byte(a[15:8], ack);      chk(ack, wcv ? "R8" : "R3", "addr hi ack", ack, 1);
    tx_byte(a[7:0], ack);       chk(ack, wcv ? "R8" : "R3", "addr lo ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      tx_byte(d, ack);
      chk(ack == !wcv, wcv ? "R8" : "R4", "data ack", ack, !wcv);
      if (!wcv) pg[slot(off, k)] = d;
    end
    for (int k = 0; k < abort_bits; k++) tx_bit(1'($urandom));
    tx_stop();
    commit = (n > 0) && !wcv && (abort_bits == 0);
    t = 0;
    while (!busy && t < 12) begin w(1); t++; end
    chk(busy == commit, commit ? "R6" : "R5", "busy after stop", busy, commit);
    if (commit && probe) begin
      w(4);
      tx_start();
      tx_byte({CODE, 1'b0}, ack);
      chk(!ack, "R7", "select ack while busy", ack, 0);
      chk(busy, "R7", "busy during probe", busy, 1);
      tx_stop();
      while (busy) w(1);
    end else begin
      bc = 0;
      while (busy) begin bc++; w(1); end
      if (commit) chk(bc == WRC, "R6", "busy length", bc, WRC);
    end
    w(8);
    if (commit) begin
      for (int k = 0; k < 32; k++) model[page * 32 + k] = pg[k];
      exp_ptr = 12'(page * 32 + slot(off, n));
    end
    chk(ptr == exp_ptr, "R9", "address pointer", ptr, exp_ptr);
    check_page(page, commit ? "R4" : (wcv ? "R8" : "R5"));
    wc = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL R6 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    w(5);
    chk(busy == 1'b0, "R10", "busy at reset", busy, 0);
    chk(sda_oe == 1'b0, "R10", "sda_oe at reset", sda_oe, 0);
    chk(ptr == 12'h000, "R10", "ptr at reset", ptr, 0);
    rst_n = 1'b1;
    w(5);

    // fill pages 0..3 so that every later comparison has known contents
    for (int p = 0; p < 4; p++) write_txn(16'(p * 32), 32, 1'b0, 0, 1'b0);

    // R2: wrong device code, then a read request
    tx_start();
    tx_byte({7'h51, 1'b0}, ack); chk(!ack, "R2", "foreign code ack", ack, 0);
    tx_byte(8'h00, ack);         chk(!ack, "R2", "byte after foreign code", ack, 0);
    tx_stop(); w(8);
    tx_start();
    tx_byte({CODE, 1'b1}, ack);  chk(!ack, "R2", "read request ack", ack, 0);
    tx_stop(); w(8);
    chk(!busy, "R2", "no cycle after ignored select", busy, 0);

    // R1: repeated start in the middle restarts the transaction
    tx_start();
    tx_byte({CODE, 1'b0}, ack); chk(ack, "R1", "first select ack", ack, 1);
    tx_byte(8'h00, ack);
    write_txn(16'hF0_45, 3, 1'b0, 0, 1'b0);

    // R5: stop right after the address bytes, and stop inside a data byte
    write_txn(16'h0021, 0, 1'b0, 0, 1'b0);
    write_txn(16'h0047, 2, 1'b0, 3, 1'b0);
    write_txn(16'h0060, 1, 1'b0, 5, 1'b0);

    // R8: write control held high
    write_txn(16'h0013, 4, 1'b1, 0, 1'b0);

    // R4: burst longer than a page overwrites its start
    write_txn(16'h003C, 35, 1'b0, 0, 1'b0);

    // R7: own select code during the write cycle
    write_txn(16'h0051, 2, 1'b0, 0, 1'b1);

    // random mix; R3 random upper address bits are ignored
    for (int r = 0; r < 20; r++) begin
      logic [15:0] a;
      int n, ab;
      bit wv;
      a  = {4'($urandom), 3'b000, 2'($urandom), 5'($urandom), 2'b00};
      a[6:0] = 7'($urandom);
      n  = 1 + int'($urandom % 40);
      wv = ($urandom % 6) == 0;
      ab = (($urandom % 6) == 0) ? 1 + int'($urandom % 7) : 0;
      write_txn(a, n, wv, ab, 1'b0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule